// File: doc/BRIEF.md
# Dual-Mode Multiplexed Bus Slave Interface

This block lets a host reach a 128-location byte space over an 8-bit bus that carries the address and the data on the same lines. A positive address-strobe pulse splits each cycle: the location is taken from the low seven lines when that strobe falls, and the next time the strobe rises the held location is cleared again. After that the same lines carry data. A static strap picks how the other two control pins are read. In data-strobe mode one pin is a positive data strobe and the other is a read/write level. In read/write-strobe mode the two pins are separate active-low read and write strobes.

Every bus input passes through a two-flop synchronizer into the system clock. All edge detection happens in that clock domain. An access needs three things: an active chip select, an inactive inhibit input, and a held address. A cycle that lacks any of them still latches its address but causes no access. On the storage side the block gives a read pulse, a write pulse with data and a per-bit write mask, and an output enable for the shared lines. Writes are blocked at the two status locations and at the top bit of the seconds and rate-control bytes.

Top module: `mux_bus_slave`

## Requirements
- R1: When `as_i` falls, `ad_i[6:0]` is latched and appears on `mem_addr` on the third rising clock edge after the change.
- R2: When `as_i` rises, `mem_addr` returns to 0 on the third clock edge whatever `cs_n_i` is. Until the next fall of `as_i`, no read or write can take place.
- R3: In data-strobe mode (`mode_i`=1), a high `ds_i` with a high `rw_i` is a read. `mem_rd` pulses for exactly one cycle, two edges after the strobe rises. On the next edge `ad_oe` goes to 1, and `ad_out` then holds the `mem_rdata` value for the latched address.
- R4: In data-strobe mode, a high `ds_i` with a low `rw_i` is a write. On the third edge after `ds_i` falls, `mem_wr` pulses for exactly one cycle and carries the data last seen on `ad_i` during the strobe. `mem_wr` and `ad_oe` are never high together.
- R5: In read/write-strobe mode (`mode_i`=0), a low `ds_i` is an active-low read strobe. It gives the same `mem_rd` pulse and the same `ad_oe` and `ad_out` behaviour as R3.
- R6: In read/write-strobe mode, a low `rw_i` is an active-low write strobe. The write is committed by one `mem_wr` pulse on the third edge after `rw_i` rises.
- R7: With `cs_n_i` high, the address still latches, but no `mem_rd` pulse or `mem_wr` pulse occurs and `ad_oe` stays 0.
- R8: With `inhibit_i` high, no `mem_rd` pulse or `mem_wr` pulse occurs and `ad_oe` stays 0.
- R9: `ad_oe` returns to 0 on the third edge after the read ends. In data-strobe mode the read ends when `ds_i` falls; in read/write-strobe mode it ends when `ds_i` rises.
- R10: Writes to locations 12 and 13 give no `mem_wr` pulse. Writes to locations 0 and 10 carry `mem_wmask`=8'h7F, which masks bit 7. Writes to every other location carry `mem_wmask`=8'hFF.
- R11: While `rst_n` is low, `ad_oe`, `mem_rd` and `mem_wr` are 0 and `mem_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Strap: 1 = data strobe with read/write level, 0 = separate active-low read and write strobes |
| as_i | input | 1 | Address strobe, a positive pulse |
| ds_i | input | 1 | Data strobe (mode 1) or active-low read strobe (mode 0) |
| rw_i | input | 1 | Read/write level (mode 1) or active-low write strobe (mode 0) |
| cs_n_i | input | 1 | Active-low chip select |
| inhibit_i | input | 1 | High forces chip select inactive |
| ad_i | input | 8 | Multiplexed address/data lines as seen by the block |
| ad_out | output | 8 | Read data to drive onto the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| mem_addr | output | 7 | Latched location |
| mem_rd | output | 1 | One-cycle read pulse to storage |
| mem_rdata | input | 8 | Storage data at `mem_addr` |
| mem_wr | output | 1 | One-cycle write pulse to storage |
| mem_wdata | output | 8 | Write data |
| mem_wmask | output | 8 | Per-bit write enable |

## Verification
Each pin change takes two edges to cross the synchronizer, and the result is registered on the third edge. So `mem_addr`, `ad_oe` and `mem_wr` change on the third rising edge after a stimulus. `mem_rd` is decoded from the synchronized strobes and shows after the second. The bench drives on falling edges and samples on falling edges after a counted number of rising ones. For each of these outputs it checks one edge early, the due edge, and one edge late. In the address sweeps each access is given several idle cycles. A write monitor counts `mem_wr` pulses and records their contents, so that each write can be compared with the expected count, data and mask.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic {
    BUS_RDWR = 1'b0,
    BUS_DSRW = 1'b1
  } bus_mode_e;

  localparam int unsigned LOC_SECONDS = 0;
  localparam int unsigned LOC_RATE    = 10;
  localparam int unsigned LOC_FLAGS   = 12;
  localparam int unsigned LOC_VALID   = 13;
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
  parameter int unsigned AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          as_s,
  input  logic [AW-1:0] ad_s,
  output logic [AW-1:0] addr,
  output logic          valid
);
  logic          as_prev_q;
  logic [AW-1:0] addr_q, addr_d;
  logic          valid_q, valid_d;
  logic          as_fall, as_rise;

  assign as_fall = as_prev_q & ~as_s;
  assign as_rise = ~as_prev_q & as_s;

  always_comb begin
    addr_d  = addr_q;
    valid_d = valid_q;
    if (as_rise) begin
      addr_d  = '0;
      valid_d = 1'b0;
    end else if (as_fall) begin
      addr_d  = ad_s;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_prev_q <= 1'b0;
      addr_q    <= '0;
      valid_q   <= 1'b0;
    end else begin
      as_prev_q <= as_s;
      if (as_rise || as_fall) begin
        addr_q  <= addr_d;
        valid_q <= valid_d;
      end
    end
  end

  assign addr  = addr_q;
  assign valid = valid_q;
endmodule

// File: rtl/mbus_strobe.sv
module mbus_strobe #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_ds,
  input  logic          ds_s,
  input  logic          rw_s,
  input  logic          sel,
  input  logic [DW-1:0] ad_s,
  input  logic [DW-1:0] mem_rdata,
  output logic          rd_pulse,
  output logic          oe,
  output logic [DW-1:0] rdata,
  output logic          wr_pulse,
  output logic [DW-1:0] wdata
);
  logic          rd_strobe, wr_strobe, rd_act, wr_act, commit;
  logic          oe_q, oe_d;
  logic          wph_q, wph_d;
  logic          wpls_q, wpls_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic [DW-1:0] wbuf_q, wbuf_d;
  logic [DW-1:0] wout_q, wout_d;

  always_comb begin
    if (mode_ds == mbus_pkg::BUS_DSRW) begin
      rd_strobe = ds_s & rw_s;
      wr_strobe = ds_s & ~rw_s;
    end else begin
      rd_strobe = ~ds_s & rw_s;
      wr_strobe = ~rw_s;
    end
  end

  assign rd_act   = rd_strobe & sel & ~wph_q;
  assign wr_act   = wr_strobe & sel;
  assign commit   = wph_q & ~wr_strobe;
  assign rd_pulse = rd_act & ~oe_q;

  always_comb begin
    oe_d    = rd_act;
    rdata_d = rd_pulse ? mem_rdata : rdata_q;
    wph_d   = wr_act;
    wbuf_d  = wr_act ? ad_s : wbuf_q;
    wpls_d  = commit;
    wout_d  = commit ? wbuf_q : wout_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q    <= 1'b0;
      wph_q   <= 1'b0;
      wpls_q  <= 1'b0;
      rdata_q <= '0;
      wbuf_q  <= '0;
      wout_q  <= '0;
    end else begin
      oe_q   <= oe_d;
      wph_q  <= wph_d;
      wpls_q <= wpls_d;
      if (rd_pulse) rdata_q <= rdata_d;
      if (wr_act)   wbuf_q  <= wbuf_d;
      if (commit)   wout_q  <= wout_d;
    end
  end

  assign oe       = oe_q;
  assign rdata    = rdata_q;
  assign wr_pulse = wpls_q;
  assign wdata    = wout_q;
endmodule

// File: rtl/mbus_wprot.sv
module mbus_wprot #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic [AW-1:0] addr,
  input  logic          wr_req,
  output logic          wr_ok,
  output logic [DW-1:0] mask
);
  logic ro_loc, top_locked;

  always_comb begin
    ro_loc     = (addr == AW'(mbus_pkg::LOC_FLAGS)) || (addr == AW'(mbus_pkg::LOC_VALID));
    top_locked = (addr == AW'(mbus_pkg::LOC_SECONDS)) || (addr == AW'(mbus_pkg::LOC_RATE));
    wr_ok      = wr_req & ~ro_loc;
    if (ro_loc)          mask = '0;
    else if (top_locked) mask = {1'b0, {(DW-1){1'b1}}};
    else                 mask = '1;
  end
endmodule

// File: rtl/mux_bus_slave.sv
module mux_bus_slave #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_i,
  input  logic          as_i,
  input  logic          ds_i,
  input  logic          rw_i,
  input  logic          cs_n_i,
  input  logic          inhibit_i,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] mem_wmask
);
  localparam int unsigned CW = 6;
  localparam int unsigned SW = DW + CW;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, {DW{1'b0}}};

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [SW-1:0] raw_bus, syn_bus;
  logic          mode_s, inh_s, cs_n_s, rw_s, ds_s, as_s;
  logic [DW-1:0] ad_s;

  assign raw_bus = {mode_i, inhibit_i, cs_n_i, rw_i, ds_i, as_i, ad_i};
  assign {mode_s, inh_s, cs_n_s, rw_s, ds_s, as_s, ad_s} = syn_bus;

  mbus_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_sync_q), .d(raw_bus), .q(syn_bus)
  );

  logic [AW-1:0] addr;
  logic          addr_valid;

  mbus_addr_latch #(.AW(AW)) u_alat (
    .clk(clk), .rst_n(rst_sync_q), .as_s(as_s), .ad_s(ad_s[AW-1:0]),
    .addr(addr), .valid(addr_valid)
  );

  logic sel;
  assign sel = ~cs_n_s & ~inh_s & addr_valid;

  logic wr_pulse;

  mbus_strobe #(.DW(DW)) u_strb (
    .clk(clk), .rst_n(rst_sync_q), .mode_ds(mode_s), .ds_s(ds_s), .rw_s(rw_s),
    .sel(sel), .ad_s(ad_s), .mem_rdata(mem_rdata), .rd_pulse(mem_rd),
    .oe(ad_oe), .rdata(ad_out), .wr_pulse(wr_pulse), .wdata(mem_wdata)
  );

  mbus_wprot #(.AW(AW), .DW(DW)) u_wprot (
    .addr(addr), .wr_req(wr_pulse), .wr_ok(mem_wr), .mask(mem_wmask)
  );

  assign mem_addr = addr;
endmodule

// File: rtl/mux_bus_slave_chk.sv
module mux_bus_slave_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ad_oe,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wmask
);
  // R4: write pulse lasts one cycle
  a_r4_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);

  // R4: never write while driving the bus
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && ad_oe));

  // R10: status locations never receive a write
  a_r10_ro_loc: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr != AW'(mbus_pkg::LOC_FLAGS)) && (mem_addr != AW'(mbus_pkg::LOC_VALID)));

  // R10: top bit masked at seconds and rate locations
  a_r10_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && ((mem_addr == AW'(mbus_pkg::LOC_SECONDS)) || (mem_addr == AW'(mbus_pkg::LOC_RATE))))
      |-> !mem_wmask[DW-1]);

  // R3: output enable rises only after a read pulse
  a_r3_oe_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |-> $past(mem_rd));

  // R3: read pulse lasts one cycle
  a_r3_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
endmodule

bind mux_bus_slave mux_bus_slave_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ad_oe(ad_oe), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_addr(mem_addr), .mem_wmask(mem_wmask)
);

// File: tb/tb_mux_bus_slave.sv
`timescale 1ns/1ps
module tb_mux_bus_slave;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_i, as_i, ds_i, rw_i, cs_n_i, inhibit_i;
  logic [7:0] ad_i, ad_out, mem_rdata, mem_wdata, mem_wmask;
  logic       ad_oe, mem_rd, mem_wr;
  logic [6:0] mem_addr;

  int total = 0;
  int bad = 0;
  int wr_cnt = 0;
  logic [6:0] last_waddr;
  logic [7:0] last_wdata, last_wmask;

  always #2 clk = ~clk;

  assign mem_rdata = {1'b0, mem_addr} ^ 8'h5A;

  mux_bus_slave dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .as_i(as_i), .ds_i(ds_i),
    .rw_i(rw_i), .cs_n_i(cs_n_i), .inhibit_i(inhibit_i), .ad_i(ad_i),
    .ad_out(ad_out), .ad_oe(ad_oe), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_wmask(mem_wmask)
  );

  always @(negedge clk) begin
    if (rst_n && mem_wr) begin
      wr_cnt     <= wr_cnt + 1;
      last_waddr <= mem_addr;
      last_wdata <= mem_wdata;
      last_wmask <= mem_wmask;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_mode(input logic m);
    cs_n_i = 1'b1;
    step(1);
    mode_i = m;
    ds_i   = m ? 1'b0 : 1'b1;
    rw_i   = 1'b1;
    step(5);
    cs_n_i = 1'b0;
    step(1);
  endtask

  task automatic addr_phase(input logic [6:0] a);
    ad_i = {1'b0, a};
    as_i = 1'b1;
    step(4);
    as_i = 1'b0;
    step(4);
  endtask

  task automatic bus_write(input logic [6:0] a, input logic [7:0] d);
    addr_phase(a);
    ad_i = d;
    rw_i = 1'b0;
    step(4);
    if (mode_i) begin
      ds_i = 1'b1;
      step(4);
      ds_i = 1'b0;
      step(4);
    end
    rw_i = 1'b1;
    step(5);
  endtask

  task automatic bus_read(input logic [6:0] a, output logic [7:0] got, output logic oe_seen);
    addr_phase(a);
    ds_i = mode_i ? 1'b1 : 1'b0;
    step(4);
    oe_seen = ad_oe;
    got     = ad_out;
    ds_i = mode_i ? 1'b0 : 1'b1;
    step(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] got;
    logic       oe_seen;
    int         w0;
    rst_n = 1'b0; mode_i = 1'b1; as_i = 1'b0; ds_i = 1'b0; rw_i = 1'b1;
    cs_n_i = 1'b0; inhibit_i = 1'b0; ad_i = 8'h00;
    step(3);
    // R11 reset state
    chk(ad_oe == 1'b0, "R11 oe", ad_oe, 0);
    chk(mem_wr == 1'b0 && mem_rd == 1'b0, "R11 pulses", {mem_wr, mem_rd}, 0);
    chk(mem_addr == 7'd0, "R11 addr", mem_addr, 0);
    rst_n = 1'b1;
    step(6);
    set_mode(1'b1);

    // R1 exact latency of address latch
    ad_i = 8'h35; as_i = 1'b1; step(4);
    as_i = 1'b0; step(2);
    chk(mem_addr == 7'd0, "R1 early", mem_addr, 0);
    step(1);
    chk(mem_addr == 7'h35, "R1 due", mem_addr, 'h35);
    // R2 clear on rise
    as_i = 1'b1; step(2);
    chk(mem_addr == 7'h35, "R2 early", mem_addr, 'h35);
    step(1);
    chk(mem_addr == 7'd0, "R2 clear", mem_addr, 0);
    // R2 no access without held address
    ds_i = 1'b1; step(4);
    chk(ad_oe == 1'b0, "R2 no read", ad_oe, 0);
    ds_i = 1'b0; as_i = 1'b0; ad_i = 8'h00; step(4);

    // R3 / R9 exact read timing, data-strobe mode
    addr_phase(7'h21);
    ds_i = 1'b1; step(2);
    chk(mem_rd == 1'b1 && ad_oe == 1'b0, "R3 rd pulse", {mem_rd, ad_oe}, 2);
    step(1);
    chk(ad_oe == 1'b1 && mem_rd == 1'b0, "R3 oe due", {mem_rd, ad_oe}, 1);
    chk(ad_out == (8'h21 ^ 8'h5A), "R3 data", ad_out, 8'h21 ^ 8'h5A);
    ds_i = 1'b0; step(2);
    chk(ad_oe == 1'b1, "R9 early", ad_oe, 1);
    step(1);
    chk(ad_oe == 1'b0, "R9 release", ad_oe, 0);

    // R4 exact write timing
    addr_phase(7'h22);
    ad_i = 8'h3C; rw_i = 1'b0; step(4);
    ds_i = 1'b1; step(4);
    ds_i = 1'b0; step(2);
    chk(mem_wr == 1'b0, "R4 early", mem_wr, 0);
    step(1);
    chk(mem_wr == 1'b1 && mem_wdata == 8'h3C, "R4 due", {mem_wr, mem_wdata}, 'h13C);
    step(1);
    chk(mem_wr == 1'b0, "R4 single", mem_wr, 0);
    rw_i = 1'b1; step(4);

    // R4 / R10 write sweep, data-strobe mode
    for (int a = 0; a < 128; a++) begin
      logic [7:0] d;
      d  = 8'(a * 7 + 3);
      w0 = wr_cnt;
      bus_write(7'(a), d);
      if (a == 12 || a == 13) begin
        chk(wr_cnt == w0, "R10 ro loc", wr_cnt - w0, 0);
      end else begin
        chk(wr_cnt == w0 + 1, "R4 count", wr_cnt - w0, 1);
        chk(last_waddr == 7'(a) && last_wdata == d, "R4 data", last_wdata, d);
        chk(last_wmask == ((a == 0 || a == 10) ? 8'h7F : 8'hFF), "R10 mask",
            last_wmask, (a == 0 || a == 10) ? 8'h7F : 8'hFF);
      end
    end
    // R3 read sweep
    for (int a = 0; a < 128; a++) begin
      bus_read(7'(a), got, oe_seen);
      chk(oe_seen && got == (8'(a) ^ 8'h5A), "R3 sweep", got, 8'(a) ^ 8'h5A);
    end

    // R7 chip select high
    cs_n_i = 1'b1;
    w0 = wr_cnt;
    bus_write(7'h44, 8'h99);
    chk(wr_cnt == w0, "R7 no write", wr_cnt - w0, 0);
    chk(mem_addr == 7'h44, "R7 addr latched", mem_addr, 'h44);
    bus_read(7'h45, got, oe_seen);
    chk(oe_seen == 1'b0, "R7 no read", oe_seen, 0);
    cs_n_i = 1'b0;

    // R8 inhibit
    inhibit_i = 1'b1;
    w0 = wr_cnt;
    bus_write(7'h46, 8'h11);
    chk(wr_cnt == w0, "R8 no write", wr_cnt - w0, 0);
    bus_read(7'h47, got, oe_seen);
    chk(oe_seen == 1'b0, "R8 no read", oe_seen, 0);
    inhibit_i = 1'b0;
    step(4);

    // read/write-strobe mode
    set_mode(1'b0);
    addr_phase(7'h19);
    ds_i = 1'b0; step(2);
    chk(mem_rd == 1'b1, "R5 rd pulse", mem_rd, 1);
    step(1);
    chk(ad_oe == 1'b1 && ad_out == (8'h19 ^ 8'h5A), "R5 read", ad_out, 8'h19 ^ 8'h5A);
    ds_i = 1'b1; step(2);
    chk(ad_oe == 1'b1, "R9 rd early", ad_oe, 1);
    step(1);
    chk(ad_oe == 1'b0, "R9 rd release", ad_oe, 0);

    addr_phase(7'h1A);
    ad_i = 8'hC3; rw_i = 1'b0; step(4);
    rw_i = 1'b1; step(2);
    chk(mem_wr == 1'b0, "R6 early", mem_wr, 0);
    step(1);
    chk(mem_wr == 1'b1 && mem_wdata == 8'hC3, "R6 due", {mem_wr, mem_wdata}, 'h1C3);
    step(4);

    for (int a = 0; a < 128; a++) begin
      logic [7:0] d;
      d  = 8'(a * 13 + 5);
      w0 = wr_cnt;
      bus_write(7'(a), d);
      if (a == 12 || a == 13) begin
        chk(wr_cnt == w0, "R10 ro loc rw", wr_cnt - w0, 0);
      end else begin
        chk(wr_cnt == w0 + 1 && last_wdata == d, "R6 data", last_wdata, d);
        chk(last_wmask == ((a == 0 || a == 10) ? 8'h7F : 8'hFF), "R10 mask rw",
            last_wmask, (a == 0 || a == 10) ? 8'h7F : 8'hFF);
      end
    end
    for (int a = 0; a < 128; a++) begin
      bus_read(7'(a), got, oe_seen);
      chk(oe_seen && got == (8'(a) ^ 8'h5A), "R5 sweep", got, 8'(a) ^ 8'h5A);
    end

    cs_n_i = 1'b1;
    w0 = wr_cnt;
    bus_write(7'h50, 8'h77);
    chk(wr_cnt == w0, "R7 rw no write", wr_cnt - w0, 0);
    cs_n_i = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule